// File: doc/BRIEF.md
# Clock Source Select Controller

This block owns the clock-source control register of a CPU that can run either from a fast main oscillator or from a slow subsystem oscillator. The register sits at one data-memory address. It holds two live bits: a source-select bit (bit 0) and a main-oscillator stop bit (bit 3). Software changes it either with a single-bit set or clear, or with a nibble write. A nibble write is accepted only when it changes at most one of the two live bits.

The controller enforces the legality rules between the two bits and the prescaler code, which it also holds. A blocked request leaves the state untouched and raises a sticky error flag. The move to a new source is paced by a one-cycle tick that marks each subsystem-clock period; the active-source output changes only on such a tick. Two counters gate the oscillator-stop and switch-back requests:
- a dwell counter runs after the switch to the slow clock and must complete before the stop bit can be set;
- a settle counter runs after the main oscillator is restarted and must complete before the source can return to main.

When the main oscillator is stopped, its enable is dropped and its input clamp is asserted.

Top module: `clk_src_ctl`

## Requirements
- R1: After reset the register reads 4'b0000, the active source is main (src_sub_o = 0), osc_en_o = 1, clamp_o = 0, err_o = 0 and pcc_o = 4'b0000.
- R2: Only writes with wr_addr_i equal to SCC_ADDR (default 12'hFB7) affect the register. Read-back is {stop, 1'b0, 1'b0, sel}. A write to bit 1 or bit 2 has no effect.
- R3: With wr_bitop_i = 1, bit wr_bit_i receives wr_data_i[0]. With wr_bitop_i = 0, sel takes wr_data_i[0] and stop takes wr_data_i[3]. A nibble write that would change both sel and stop is rejected and sets err_o. A nibble write that changes only one of them is treated like the matching bit operation.
- R4: src_sub_o takes the value of sel at the first clock edge where sub_tick_i = 1 and the two differ. It never changes on an edge without sub_tick_i.
- R5: Setting sel is blocked, and err_o is set, while pcc_o = 4'b0001.
- R6: A prescaler write of 4'b0001 is blocked, and err_o is set, when sel (after this cycle's register write) or src_sub_o is 1. Any other code is accepted.
- R7: Setting stop is accepted only when sel = 1, src_sub_o = 1, and at least STOP_WAIT ticks have occurred since src_sub_o rose. Otherwise it is blocked and err_o is set.
- R8: While stop = 1, osc_en_o = 0 and clamp_o = 1. While stop = 0, osc_en_o = 1 and clamp_o = 0.
- R9: Clearing sel is blocked, and err_o is set, while stop = 1 or until SETTLE_TICKS ticks have occurred since stop was cleared.
- R10: err_o stays 1 until reset once any blocked request has set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sub_tick_i | input | 1 | One-cycle pulse per subsystem-clock period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Data-memory address of the write |
| wr_bitop_i | input | 1 | 1 = single-bit operation, 0 = nibble write |
| wr_bit_i | input | 2 | Bit index for a single-bit operation |
| wr_data_i | input | 4 | Bit value in [0] for bit operations, or nibble data |
| pcc_we_i | input | 1 | Prescaler code write strobe |
| pcc_data_i | input | 4 | New prescaler code |
| pcc_o | output | 4 | Current prescaler code |
| scc_rd_o | output | 4 | Register read-back |
| src_sub_o | output | 1 | 1 = CPU running from the subsystem clock |
| osc_en_o | output | 1 | Main oscillator enable |
| clamp_o | output | 1 | Main oscillator input clamp to ground |
| err_o | output | 1 | Sticky blocked-request flag |

## Verification
The bench targets the orderings around the switch:
- A stop request right after the source changes. A design without the dwell count would stop the oscillator early.
- A switch back to main right after the oscillator restarts. A design without the settle count would return to an unsettled clock.
- A nibble write that flips both bits. A design that accepts it would reach the prohibited combination of main selected with the oscillator stopped.
- The divide-by-16 prescaler code written from both sides of a switch. A missing interlock would leave the slow clock divided further.

Every clock, a behavioural model is compared with all outputs. It catches a source change that happens off a tick, or one that arrives a cycle early or late.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int unsigned BIT_SEL  = 0;
  localparam int unsigned BIT_STOP = 3;
  localparam logic [3:0]  PCC_DIV16 = 4'b0001;

  function automatic logic [3:0] pack_scc(input logic stop, input logic sel);
    return {stop, 2'b00, sel};
  endfunction
endpackage

// File: rtl/ccs_tick_cnt.sv
module ccs_tick_cnt #(
  parameter int unsigned LIMIT    = 4,
  parameter bit          FULL_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);
  localparam logic [CW-1:0] RST_VAL = FULL_RST ? LIM : '0;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= RST_VAL;
    else if (clr_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);

  a_r7_cnt_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ccs_src_sync.sv
module ccs_src_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic tick_i,
  output logic src_sub_o
);
  logic src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      src_q <= 1'b0;
    else if (tick_i && src_q != sel_i) src_q <= sel_i;
  end

  assign src_sub_o = src_q;

  a_r4_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(src_q));
  a_r4_follow_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (src_q == $past(sel_i)));
endmodule

// File: rtl/ccs_scc_ctl.sv
module ccs_scc_ctl
  import ccs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] SCC_ADDR = 12'hFB7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_bitop_i,
  input  logic [1:0]        wr_bit_i,
  input  logic [3:0]        wr_data_i,
  input  logic              pcc_we_i,
  input  logic [3:0]        pcc_data_i,
  input  logic              src_sub_i,
  input  logic              dwell_done_i,
  input  logic              settle_done_i,
  output logic              sel_o,
  output logic              stop_o,
  output logic [3:0]        pcc_o,
  output logic              err_o
);
  logic sel_q, stop_q, err_q;
  logic [3:0] pcc_q;
  logic hit, want_sel, want_stop, chg_sel, chg_stop, both;
  logic sel_ok, stop_ok, sel_acc, stop_acc, sel_d, pcc_blk, err_set;
  logic unused_bits;

  assign unused_bits = &{1'b0, wr_data_i[2:1]};
  assign hit = wr_en_i && (wr_addr_i == SCC_ADDR);

  always_comb begin
    want_sel  = sel_q;
    want_stop = stop_q;
    if (wr_bitop_i) begin
      if (wr_bit_i == 2'(BIT_SEL))  want_sel  = wr_data_i[0];
      if (wr_bit_i == 2'(BIT_STOP)) want_stop = wr_data_i[0];
    end else begin
      want_sel  = wr_data_i[BIT_SEL];
      want_stop = wr_data_i[BIT_STOP];
    end
  end

  assign chg_sel  = hit && (want_sel != sel_q);
  assign chg_stop = hit && (want_stop != stop_q);
  assign both     = chg_sel && chg_stop;

  // set: prescaler must not be div16; clear: oscillator running and settled
  assign sel_ok  = want_sel ? (pcc_q != PCC_DIV16) : (!stop_q && settle_done_i);
  assign stop_ok = want_stop ? (sel_q && src_sub_i && dwell_done_i) : 1'b1;

  assign sel_acc  = chg_sel && !both && sel_ok;
  assign stop_acc = chg_stop && !both && stop_ok;
  assign sel_d    = sel_acc ? want_sel : sel_q;
  assign pcc_blk  = pcc_we_i && (pcc_data_i == PCC_DIV16) && (sel_d || src_sub_i);
  assign err_set  = both || (chg_sel && !both && !sel_ok) ||
                    (chg_stop && !both && !stop_ok) || pcc_blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      stop_q <= 1'b0;
      pcc_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      if (stop_acc) stop_q <= want_stop;
      if (pcc_we_i && !pcc_blk) pcc_q <= pcc_data_i;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign sel_o  = sel_q;
  assign stop_o = stop_q;
  assign pcc_o  = pcc_q;
  assign err_o  = err_q;

  a_r3_no_dual_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && both) |=> ($stable(sel_q) && $stable(stop_q)));
  a_r7_stop_on_sub_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |-> (sel_q && src_sub_i));
  a_r7_stop_after_dwell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_q) |-> $past(dwell_done_i));
  a_r5_no_sel_on_div16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_q) |-> ($past(pcc_q) != PCC_DIV16));
  a_r6_no_div16_on_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q || src_sub_i) |-> (pcc_q != PCC_DIV16));
  a_r9_clear_after_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_q) |-> ($past(settle_done_i) && !$past(stop_q)));
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
  import ccs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] SCC_ADDR = 12'hFB7,
  parameter int unsigned STOP_WAIT    = 4,
  parameter int unsigned SETTLE_TICKS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sub_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_bitop_i,
  input  logic [1:0]        wr_bit_i,
  input  logic [3:0]        wr_data_i,
  input  logic              pcc_we_i,
  input  logic [3:0]        pcc_data_i,
  output logic [3:0]        pcc_o,
  output logic [3:0]        scc_rd_o,
  output logic              src_sub_o,
  output logic              osc_en_o,
  output logic              clamp_o,
  output logic              err_o
);
  logic sel, stop, src_sub, dwell_done, settle_done;

  ccs_scc_ctl #(.ADDR_W(ADDR_W), .SCC_ADDR(SCC_ADDR)) i_ctl (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_bitop_i, .wr_bit_i, .wr_data_i,
    .pcc_we_i, .pcc_data_i,
    .src_sub_i(src_sub), .dwell_done_i(dwell_done), .settle_done_i(settle_done),
    .sel_o(sel), .stop_o(stop), .pcc_o(pcc_o), .err_o(err_o)
  );

  ccs_src_sync i_sync (
    .clk_i, .rst_ni, .sel_i(sel), .tick_i(sub_tick_i), .src_sub_o(src_sub)
  );

  // dwell on slow clock before an oscillator stop is allowed
  ccs_tick_cnt #(.LIMIT(STOP_WAIT), .FULL_RST(1'b0)) i_dwell (
    .clk_i, .rst_ni, .clr_i(!src_sub), .tick_i(sub_tick_i), .done_o(dwell_done)
  );

  // main oscillator settle after restart; settled out of reset
  ccs_tick_cnt #(.LIMIT(SETTLE_TICKS), .FULL_RST(1'b1)) i_settle (
    .clk_i, .rst_ni, .clr_i(stop), .tick_i(sub_tick_i), .done_o(settle_done)
  );

  assign scc_rd_o  = pack_scc(stop, sel);
  assign src_sub_o = src_sub;
  assign osc_en_o  = !stop;
  assign clamp_o   = stop;

  a_r8_osc_off_on_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> (src_sub_o && !osc_en_o));
endmodule

// File: tb/test_clk_src_ctl.sv
`timescale 1ns/1ps
module test_clk_src_ctl;
  localparam int W = 4, S = 6, TP = 8;
  logic clk = 0, rst_n = 0, tick = 0;
  logic wr_en = 0, bitop = 0, pcc_we = 0;
  logic [11:0] addr = 0;
  logic [1:0] bidx = 0;
  logic [3:0] wdata = 0, pdata = 0;
  logic [3:0] pcc, rd;
  logic src, osc, clamp, err;
  int n_chk = 0, n_err = 0, tcnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_src_ctl #(.STOP_WAIT(W), .SETTLE_TICKS(S)) i_clk_src_ctl (
    .clk_i(clk), .rst_ni(rst_n), .sub_tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(addr),
    .wr_bitop_i(bitop), .wr_bit_i(bidx), .wr_data_i(wdata), .pcc_we_i(pcc_we),
    .pcc_data_i(pdata), .pcc_o(pcc), .scc_rd_o(rd), .src_sub_o(src),
    .osc_en_o(osc), .clamp_o(clamp), .err_o(err));

  always @(negedge clk) begin
    tcnt++;
    tick <= (tcnt % TP == 0);
  end

  // behavioural reference
  bit m_sel, m_stop, m_src, m_err;
  int m_pcc, m_dw, m_st;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_stop = 0; m_src = 0; m_err = 0; m_pcc = 0; m_dw = 0; m_st = S;
    end else begin
      bit ns, nt, cs, ct, blk;
      bit os, ot, osrc;
      ns = m_sel; nt = m_stop; os = m_sel; ot = m_stop; osrc = m_src;
      blk = 0;
      if (wr_en && addr == 12'hFB7) begin
        bit ws, wt;
        ws = m_sel; wt = m_stop;
        if (bitop) begin
          if (bidx == 0) ws = wdata[0];
          if (bidx == 3) wt = wdata[0];
        end else begin
          ws = wdata[0]; wt = wdata[3];
        end
        cs = (ws != m_sel); ct = (wt != m_stop);
        if (cs && ct) blk = 1;
        else if (cs) begin
          if (ws ? (m_pcc != 1) : (!m_stop && m_st == S)) ns = ws; else blk = 1;
        end else if (ct) begin
          if (!wt || (m_sel && m_src && m_dw == W)) nt = wt; else blk = 1;
        end
      end
      if (pcc_we) begin
        if (pdata == 1 && (ns || osrc)) blk = 1;
        else m_pcc = pdata;
      end
      if (blk) m_err = 1;
      if (tick && osrc != os) m_src = os;
      if (!osrc) m_dw = 0; else if (tick && m_dw < W) m_dw++;
      if (ot) m_st = 0; else if (tick && m_st < S) m_st++;
      m_sel = ns; m_stop = nt;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(rd == {m_stop, 2'b00, m_sel}, "R2 model rd", rd, {m_stop, 2'b00, m_sel});
    chk(src == m_src, "R4 model src", src, m_src);
    chk(osc == !m_stop && clamp == m_stop, "R8 model osc", {osc, clamp}, {!m_stop, m_stop});
    chk(err == m_err, "R10 model err", err, m_err);
    chk(pcc == m_pcc[3:0], "R6 model pcc", pcc, m_pcc);
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask
  task automatic bop(input int idx, input bit v, input logic [11:0] a = 12'hFB7);
    @(negedge clk); wr_en = 1; bitop = 1; bidx = 2'(idx); wdata = {3'b0, v}; addr = a;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic nib(input logic [3:0] d);
    @(negedge clk); wr_en = 1; bitop = 0; wdata = d; addr = 12'hFB7;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic pwr(input logic [3:0] d);
    @(negedge clk); pcc_we = 1; pdata = d;
    @(negedge clk); pcc_we = 0;
  endtask
  task automatic wait_ticks(input int n);
    repeat (n * TP + 2) @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      done = 1; n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(rd == 0 && src == 0 && osc && !clamp && !err && pcc == 0, "R1 reset",
        {rd, src, osc, clamp, err}, 8'b0000_0100);
    bop(1, 1); bop(2, 1);
    chk(rd == 0, "R2 bits 1/2 ignored", rd, 0);
    bop(0, 1, 12'hFB6);
    chk(rd == 0, "R2 wrong address ignored", rd, 0);
    bop(3, 1);
    chk(rd == 0 && err, "R7 stop on main blocked", {rd, err}, 5'b00001);
    do_reset();
    pwr(4'b0001);
    chk(pcc == 1 && !err, "R6 div16 accepted on main", {pcc, err}, 5'b00010);
    bop(0, 1);
    chk(rd == 0 && err, "R5 sel blocked on div16", {rd, err}, 5'b00001);
    pwr(4'b0010); bop(0, 1);
    chk(rd == 1 && err, "R10 err sticky", {rd, err}, 5'b00011);
    do_reset();
    pwr(4'b0010); bop(0, 1);
    chk(rd == 1 && src == 0, "R4 src waits for tick", src, 0);
    pwr(4'b0001);
    chk(pcc == 2 && err, "R6 div16 blocked with sel", {pcc, err}, 5'b00101);
    wait_ticks(1);
    chk(src == 1, "R4 src switched", src, 1);
    do_reset();
    bop(0, 1); wait_ticks(1);
    bop(3, 1);
    chk(rd == 1 && err, "R7 stop before dwell blocked", {rd, err}, 5'b00011);
    wait_ticks(W + 1);
    bop(3, 1);
    chk(rd == 4'b1001 && !osc && clamp, "R8 stop accepted", {rd, osc, clamp}, 6'b100101);
    bop(0, 0);
    chk(rd == 4'b1001, "R9 sel clear blocked while stopped", rd, 4'b1001);
    nib(4'b0000);
    chk(rd == 4'b1001, "R3 dual change rejected", rd, 4'b1001);
    nib(4'b0001);
    chk(rd == 4'b0001 && osc && !clamp, "R3 single change accepted", {rd, osc}, 5'b00011);
    bop(0, 0);
    chk(rd == 4'b0001, "R9 sel clear blocked before settle", rd, 1);
    wait_ticks(S + 1);
    bop(0, 0);
    chk(rd == 0 && src == 1, "R9 sel clear after settle", {rd, src}, 5'b00001);
    wait_ticks(1);
    chk(src == 0, "R4 back to main", src, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule